// File: doc/BRIEF.md
# Memory Low-Power Entry Controller

This block decides, chip by chip, when an idle memory device is moved into a low-power state. It runs only while the surrounding controller reports its Ready state. For each chip it counts idle memory-clock cycles against a programmed period. When that count runs out, it does one of two things. It either drops the chip's clock-enable, which is power-down, or it raises a self-refresh entry request towards the command path.

Three enable inputs select the policy: auto power-down, force precharge and auto self-refresh. Each one also has a build-time include parameter. A cleared power-down enable means no power saving at all. Self-refresh is chosen only when all three enables are set. Every other combination that has power-down set gives plain power-down.

When self-refresh support is built in, each idle counter is slowed by a programmable prescaler. Clock-enable can be per chip, or global across all chips. In global mode, entry waits until every chip is idle, and a command to any chip wakes them all.

Top module: `lp_entry_ctrl`

## Requirements
- R1: While reset is held and right after it, every clock-enable is high, and no self-refresh request, self-refresh flag or wake pulse is raised.
- R2: When power-down is enabled and self-refresh is not selected (power-down set, and not both of the other two bits set), a chip's clock-enable falls at the P-th consecutive rising edge at which the chip is idle, where P is the period input and the prescale is zero. The active-power-down flag then shows 1 if the chip had an open row at that edge, and 0 otherwise (precharge power-down).
- R3: With the power-down enable cleared, no chip ever changes state, whatever the force-precharge and self-refresh enables hold.
- R4: With all three enables set, the same expiry raises the self-refresh request instead, and clock-enable stays high. The request holds until it is acknowledged. The edge that samples the acknowledge clears the request and sets the in-self-refresh flag, which stays set until the chip is woken.
- R5: With a non-zero prescale S, and self-refresh support built in, the expiry falls at rising edge P*(S+1) of the idle stretch. This applies to power-down entry too.
- R6: A cycle in which the chip is not idle, or is hit by a command, reloads its count, so the full wait starts over. A command to a chip that is in power-down or self-refresh pulses that chip's wake output in the same cycle. Clock-enable is then high, and the self-refresh flag low, after the next edge. A command to an awake chip gives no wake pulse.
- R7: While the Ready input is low, no entry happens and the counts are held at their reload value.
- R8: In global clock-enable mode, entry needs every chip to be idle, all clock-enables switch together, and a command to any chip wakes every chip.
- R9: While power-down is enabled, the period must be greater than the CAS latency input. This is a configuration rule that is checked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock; the idle counts step on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ready_i | input | 1 | Controller is in its Ready state |
| apd_en_i | input | 1 | Auto power-down enable |
| fp_en_i | input | 1 | Force precharge enable |
| sr_en_i | input | 1 | Auto self-refresh enable |
| pd_period_i | input | PRD_W | Idle period P in (prescaled) cycles |
| prescale_i | input | PS_W | Prescale S; 0 means unscaled |
| cas_lat_i | input | CAS_W | Programmed CAS latency (configuration check) |
| chip_idle_i | input | N_CHIP | Per-chip idle status |
| row_open_i | input | N_CHIP | Per-chip open-row status |
| cmd_hit_i | input | N_CHIP | A new command targets this chip |
| sr_ack_i | input | N_CHIP | Command path accepted the self-refresh entry |
| cke_o | output | N_CHIP | Clock-enable per chip |
| pd_act_o | output | N_CHIP | Chip is in active (open-row) power-down |
| sr_req_o | output | N_CHIP | Self-refresh entry command request |
| in_sr_o | output | N_CHIP | Chip is in self-refresh |
| wake_o | output | N_CHIP | Wake request, same cycle as the waking command |

## Verification
Clock-enable, the self-refresh request and the self-refresh flag are registered. Each one changes exactly P*(S+1) edges after the edge before the first idle sample, and the first edge after a wake or an acknowledge. The wake output is combinational and is due in the very cycle the command is driven. The driver works out each due cycle from the edge count at the moment it drives stimulus, and queues the expected value there. It also queues the value one edge earlier for the expiry cases, so an off-by-one in either direction is reported. The monitor samples a moment after each falling edge, so it never races the driver or the clock.

// File: rtl/lp_entry_pkg.sv
package lp_entry_pkg;

  typedef enum logic [1:0] {
    LP_NONE,
    LP_PD,
    LP_SR
  } lp_mode_e;

  typedef enum logic [1:0] {
    CHIP_AWAKE,
    CHIP_PD,
    CHIP_SR_REQ,
    CHIP_SR
  } chip_st_e;

  // power-down gates everything; self-refresh only with force precharge too
  function automatic lp_mode_e lp_pick(input logic apd, input logic fp, input logic sr);
    if (!apd) return LP_NONE;
    if (fp && sr) return LP_SR;
    return LP_PD;
  endfunction

endpackage

// File: rtl/lp_idle_timer.sv
module lp_idle_timer #(
  parameter int PRD_W  = 8,
  parameter int PS_W   = 10,
  parameter bit USE_PS = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [PRD_W-1:0] period_i,
  input  logic [PS_W-1:0]  prescale_i,
  output logic             expire_o
);

  logic [PRD_W-1:0] cnt_q;
  logic             tick;

  generate
    if (USE_PS) begin : g_ps
      logic [PS_W-1:0] ps_q;
      always_ff @(posedge clk) begin
        if (!rst_n || !run_i) ps_q <= '0;
        else if (tick)        ps_q <= '0;
        else                  ps_q <= ps_q + 1'b1;
      end
      assign tick = (ps_q >= prescale_i);
    end else begin : g_nops
      logic unused_ps;
      assign unused_ps = ^prescale_i;
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt_q <= '1;
    else if (!run_i)             cnt_q <= period_i - 1'b1;
    else if (tick && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = run_i && tick && (cnt_q == '0);

  // R6
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == $past(period_i) - 1'b1));

endmodule

// File: rtl/lp_chip_fsm.sv
module lp_chip_fsm
  import lp_entry_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ready_i,
  input  logic     idle_i,
  input  logic     hit_i,
  input  logic     row_open_i,
  input  logic     expire_i,
  input  lp_mode_e mode_i,
  input  logic     sr_ack_i,
  output logic     cke_o,
  output logic     pd_act_o,
  output logic     sr_req_o,
  output logic     in_sr_o,
  output logic     wake_o
);

  chip_st_e state_q;
  logic     act_q;
  logic     enter;

  assign enter = expire_i && (state_q == CHIP_AWAKE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= CHIP_AWAKE;
      act_q   <= 1'b0;
    end else begin
      unique case (state_q)
        CHIP_AWAKE: begin
          if (enter && mode_i == LP_PD) begin
            state_q <= CHIP_PD;
            act_q   <= row_open_i;
          end else if (enter && mode_i == LP_SR) begin
            state_q <= CHIP_SR_REQ;
          end
        end
        CHIP_PD:     if (hit_i) state_q <= CHIP_AWAKE;
        CHIP_SR_REQ: begin
          if (sr_ack_i)   state_q <= CHIP_SR;
          else if (hit_i) state_q <= CHIP_AWAKE;
        end
        CHIP_SR:     if (hit_i) state_q <= CHIP_AWAKE;
        default:     state_q <= CHIP_AWAKE;
      endcase
    end
  end

  assign cke_o    = (state_q != CHIP_PD);
  assign pd_act_o = (state_q == CHIP_PD) && act_q;
  assign sr_req_o = (state_q == CHIP_SR_REQ);
  assign in_sr_o  = (state_q == CHIP_SR);
  assign wake_o   = hit_i && (state_q == CHIP_PD || state_q == CHIP_SR);

  // R4
  sr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_req_o && !sr_ack_i && !hit_i) |=> sr_req_o);

  // R4
  sr_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_sr_o) |-> $past(sr_ack_i));

  // R4
  lp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!cke_o, sr_req_o, in_sr_o}));

  // R6
  wake_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> (cke_o && !in_sr_o));

  // R7
  cke_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke_o) |-> $past(ready_i && idle_i));

endmodule

// File: rtl/lp_entry_ctrl.sv
module lp_entry_ctrl
  import lp_entry_pkg::*;
#(
  parameter int N_CHIP     = 2,
  parameter int PRD_W      = 8,
  parameter int PS_W       = 10,
  parameter int CAS_W      = 4,
  parameter bit INCL_APD   = 1'b1,
  parameter bit INCL_FP    = 1'b1,
  parameter bit INCL_SR    = 1'b1,
  parameter bit GLOBAL_CKE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ready_i,
  input  logic              apd_en_i,
  input  logic              fp_en_i,
  input  logic              sr_en_i,
  input  logic [PRD_W-1:0]  pd_period_i,
  input  logic [PS_W-1:0]   prescale_i,
  input  logic [CAS_W-1:0]  cas_lat_i,
  input  logic [N_CHIP-1:0] chip_idle_i,
  input  logic [N_CHIP-1:0] row_open_i,
  input  logic [N_CHIP-1:0] cmd_hit_i,
  input  logic [N_CHIP-1:0] sr_ack_i,
  output logic [N_CHIP-1:0] cke_o,
  output logic [N_CHIP-1:0] pd_act_o,
  output logic [N_CHIP-1:0] sr_req_o,
  output logic [N_CHIP-1:0] in_sr_o,
  output logic [N_CHIP-1:0] wake_o
);

  lp_mode_e          mode;
  logic [N_CHIP-1:0] eff_idle;
  logic [N_CHIP-1:0] eff_hit;
  logic [N_CHIP-1:0] run;
  logic [N_CHIP-1:0] expire;

  assign mode = lp_pick(apd_en_i & INCL_APD, fp_en_i & INCL_FP, sr_en_i & INCL_SR);

  generate
    if (GLOBAL_CKE) begin : g_glb
      assign eff_idle = {N_CHIP{&chip_idle_i}};
      assign eff_hit  = {N_CHIP{|cmd_hit_i}};
      // R8
      glb_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cke_o == '0) || (cke_o == '1));
    end else begin : g_loc
      assign eff_idle = chip_idle_i;
      assign eff_hit  = cmd_hit_i;
    end
  endgenerate

  for (genvar c = 0; c < N_CHIP; c++) begin : g_chip
    assign run[c] = ready_i && eff_idle[c] && !eff_hit[c];

    lp_idle_timer #(
      .PRD_W (PRD_W),
      .PS_W  (PS_W),
      .USE_PS(INCL_SR)
    ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (run[c]),
      .period_i  (pd_period_i),
      .prescale_i(prescale_i),
      .expire_o  (expire[c])
    );

    lp_chip_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .ready_i   (ready_i),
      .idle_i    (eff_idle[c]),
      .hit_i     (eff_hit[c]),
      .row_open_i(row_open_i[c]),
      .expire_i  (expire[c]),
      .mode_i    (mode),
      .sr_ack_i  (sr_ack_i[c]),
      .cke_o     (cke_o[c]),
      .pd_act_o  (pd_act_o[c]),
      .sr_req_o  (sr_req_o[c]),
      .in_sr_o   (in_sr_o[c]),
      .wake_o    (wake_o[c])
    );
  end

  // R9
  cfg_prd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    apd_en_i |-> (pd_period_i > PRD_W'(cas_lat_i)));

  // R3
  no_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!apd_en_i && cke_o == '1 && sr_req_o == '0 && in_sr_o == '0)
      |=> (cke_o == '1 && sr_req_o == '0));

endmodule

// File: tb/test_lp_entry_ctrl.sv
module test_lp_entry_ctrl;

  localparam int N = 2;
  localparam int P = 6;
  localparam int CAS = 3;
  localparam int S_CKE = 0, S_SRQ = 1, S_INSR = 2, S_WAKE = 3, S_ACT = 4, S_GCKE = 5, S_GWAKE = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ready = 1'b1, apd = 1'b0, fp = 1'b0, sr = 1'b0;
  logic [7:0] period = 8'(P);
  logic [9:0] prescale = '0;
  logic [3:0] cas = 4'(CAS);
  logic [N-1:0] idle = '0, row = '0, hit = '0, ack = '0;
  logic [N-1:0] g_idle = '0, g_hit = '0;
  logic [N-1:0] cke, pdact, srreq, insr, wake;
  logic [N-1:0] g_cke, g_pdact, g_srreq, g_insr, g_wake;

  always #2 clk = ~clk;

  lp_entry_ctrl i_lp_entry_ctrl (
    .clk(clk), .rst_n(rst_n), .ready_i(ready), .apd_en_i(apd), .fp_en_i(fp), .sr_en_i(sr),
    .pd_period_i(period), .prescale_i(prescale), .cas_lat_i(cas),
    .chip_idle_i(idle), .row_open_i(row), .cmd_hit_i(hit), .sr_ack_i(ack),
    .cke_o(cke), .pd_act_o(pdact), .sr_req_o(srreq), .in_sr_o(insr), .wake_o(wake));

  lp_entry_ctrl #(.GLOBAL_CKE(1'b1)) i_lp_entry_ctrl_glb (
    .clk(clk), .rst_n(rst_n), .ready_i(ready), .apd_en_i(apd), .fp_en_i(fp), .sr_en_i(sr),
    .pd_period_i(period), .prescale_i(prescale), .cas_lat_i(cas),
    .chip_idle_i(g_idle), .row_open_i(row), .cmd_hit_i(g_hit), .sr_ack_i('0),
    .cke_o(g_cke), .pd_act_o(g_pdact), .sr_req_o(g_srreq), .in_sr_o(g_insr), .wake_o(g_wake));

  typedef struct {
    int    due;
    int    sel;
    int    chip;
    logic  val;
    string tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc++;

  function automatic logic probe(int sel, int chip);
    case (sel)
      S_CKE:   return cke[chip];
      S_SRQ:   return srreq[chip];
      S_INSR:  return insr[chip];
      S_WAKE:  return wake[chip];
      S_ACT:   return pdact[chip];
      S_GCKE:  return g_cke[chip];
      default: return g_wake[chip];
    endcase
  endfunction

  // monitor: compare every expectation that falls due in this cycle
  always @(negedge clk) begin
    #1;
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        checks++;
        if (probe(q[i].sel, q[i].chip) !== q[i].val) begin
          errors++;
          $display("FAIL %s chip%0d sel%0d actual %b expected %b",
                   q[i].tag, q[i].chip, q[i].sel, probe(q[i].sel, q[i].chip), q[i].val);
        end
        q.delete(i);
      end
    end
  end

  task automatic expect_at(int d, int sel, int chip, logic v, string tag);
    q.push_back('{cyc + d, sel, chip, v, tag});
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wake_chip(int c, string tag);
    hit[c] = 1'b1;
    idle[c] = 1'b0;
    expect_at(0, S_WAKE, c, 1'b1, tag);
    expect_at(1, S_CKE, c, 1'b1, tag);
    expect_at(1, S_INSR, c, 1'b0, tag);
    step(1);
    hit[c] = 1'b0;
    expect_at(0, S_WAKE, c, 1'b0, tag);
    step(1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual hung expected finished");
    finish_run();
  end

  initial begin
    step(2);
    // R1 during reset
    for (int c = 0; c < N; c++) begin
      expect_at(0, S_CKE, c, 1'b1, "R1");
      expect_at(0, S_SRQ, c, 1'b0, "R1");
      expect_at(0, S_INSR, c, 1'b0, "R1");
      expect_at(0, S_GCKE, c, 1'b1, "R1");
    end
    step(1);
    rst_n = 1'b1;
    expect_at(1, S_CKE, 0, 1'b1, "R1");
    expect_at(1, S_WAKE, 1, 1'b0, "R1");
    step(2);

    // R9 configuration rule held by the bench
    checks++;
    if (!(P > CAS)) begin
      errors++;
      $display("FAIL R9 actual %0d expected >%0d", P, CAS);
    end

    // R3: no saving without power-down enable
    apd = 1'b0;
    for (int m = 0; m < 4; m++) begin
      fp = m[0];
      sr = m[1];
      idle = 2'b11;
      expect_at(3 * P, S_CKE, 0, 1'b1, "R3");
      expect_at(3 * P, S_CKE, 1, 1'b1, "R3");
      expect_at(3 * P, S_SRQ, 0, 1'b0, "R3");
      expect_at(3 * P, S_SRQ, 1, 1'b0, "R3");
      step(3 * P);
      idle = 2'b00;
      step(1);
    end

    // R2: mode 110, open row -> active power-down
    apd = 1'b1; fp = 1'b1; sr = 1'b0;
    row = 2'b01;
    idle = 2'b01;
    expect_at(P - 1, S_CKE, 0, 1'b1, "R2");
    expect_at(P, S_CKE, 0, 1'b0, "R2");
    expect_at(P, S_ACT, 0, 1'b1, "R2");
    expect_at(P, S_CKE, 1, 1'b1, "R2");
    step(P + 2);
    wake_chip(0, "R6");

    // R2: mode 101, no open row -> precharge power-down
    fp = 1'b0; sr = 1'b1;
    row = 2'b00;
    idle = 2'b01;
    expect_at(P - 1, S_CKE, 0, 1'b1, "R2");
    expect_at(P, S_CKE, 0, 1'b0, "R2");
    expect_at(P, S_ACT, 0, 1'b0, "R2");
    expect_at(P, S_SRQ, 0, 1'b0, "R2");
    step(P + 2);
    wake_chip(0, "R6");

    // R4: mode 111 on chip 1
    fp = 1'b1; sr = 1'b1;
    idle = 2'b10;
    expect_at(P - 1, S_SRQ, 1, 1'b0, "R4");
    expect_at(P, S_SRQ, 1, 1'b1, "R4");
    expect_at(P, S_CKE, 1, 1'b1, "R4");
    expect_at(P + 3, S_SRQ, 1, 1'b1, "R4");
    step(P + 3);
    ack = 2'b10;
    expect_at(1, S_INSR, 1, 1'b1, "R4");
    expect_at(1, S_SRQ, 1, 1'b0, "R4");
    step(1);
    ack = 2'b00;
    expect_at(5, S_INSR, 1, 1'b1, "R4");
    expect_at(5, S_CKE, 1, 1'b1, "R4");
    step(5);
    wake_chip(1, "R6");

    // R5: prescale 2 in power-down mode
    sr = 1'b0;
    prescale = 10'd2;
    idle = 2'b01;
    expect_at(3 * P - 1, S_CKE, 0, 1'b1, "R5");
    expect_at(3 * P, S_CKE, 0, 1'b0, "R5");
    step(3 * P + 1);
    wake_chip(0, "R6");
    prescale = '0;

    // R6: a non-idle cycle restarts the wait
    idle = 2'b01;
    step(P - 2);
    idle = 2'b00;
    step(1);
    idle = 2'b01;
    expect_at(P - 1, S_CKE, 0, 1'b1, "R6");
    expect_at(P, S_CKE, 0, 1'b0, "R6");
    step(P + 1);
    wake_chip(0, "R6");

    // R6: a command to an awake chip restarts the wait, no wake pulse
    idle = 2'b01;
    step(3);
    hit = 2'b01;
    expect_at(0, S_WAKE, 0, 1'b0, "R6");
    step(1);
    hit = 2'b00;
    expect_at(P - 1, S_CKE, 0, 1'b1, "R6");
    expect_at(P, S_CKE, 0, 1'b0, "R6");
    step(P + 1);
    wake_chip(0, "R6");

    // R7: not Ready -> no entry
    ready = 1'b0;
    idle = 2'b01;
    expect_at(2 * P, S_CKE, 0, 1'b1, "R7");
    step(2 * P);
    ready = 1'b1;
    expect_at(P - 1, S_CKE, 0, 1'b1, "R7");
    expect_at(P, S_CKE, 0, 1'b0, "R7");
    step(P + 1);
    wake_chip(0, "R6");

    // R8: global clock-enable instance
    g_idle = 2'b01;
    expect_at(2 * P, S_GCKE, 0, 1'b1, "R8");
    expect_at(2 * P, S_GCKE, 1, 1'b1, "R8");
    step(2 * P);
    g_idle = 2'b11;
    expect_at(P - 1, S_GCKE, 0, 1'b1, "R8");
    expect_at(P, S_GCKE, 0, 1'b0, "R8");
    expect_at(P, S_GCKE, 1, 1'b0, "R8");
    step(P + 1);
    g_hit = 2'b10;
    g_idle = 2'b01;
    expect_at(0, S_GWAKE, 0, 1'b1, "R8");
    expect_at(0, S_GWAKE, 1, 1'b1, "R8");
    expect_at(1, S_GCKE, 0, 1'b1, "R8");
    expect_at(1, S_GCKE, 1, 1'b1, "R8");
    step(1);
    g_hit = 2'b00;
    g_idle = 2'b00;
    step(3);

    while (q.size() != 0) step(1);
    step(1);
    finish_run();
  end

endmodule